// File: doc/BRIEF.md
# Three-Channel Auto-Reload Down Timer

This block holds three independent timer channels. Each has a 32-bit down-counter and a 32-bit reload constant, and all of them sit behind a small word-addressed register port. A shared start register holds one run bit per channel. When a running channel's counter is at zero and a count event arrives, the counter reloads from its constant, so the period is the constant plus one. A sticky underflow flag is set at the same moment. If the channel's underflow interrupt is enabled, the flag drives a level interrupt until software clears it.

A channel counts one of two sources. The first is a tick from a shared prescaler that divides the block clock by 4, 16, 64, 256 or 1024. The second is the chosen edges of an external clock pin. That pin is synchronized by two flip-flops and is honoured only while its input enable is set. The last channel can also capture its current count into a capture register on chosen edges of a dedicated capture pin. A capture sets its own flag and can raise its own interrupt.

The register map uses word addresses. Address 0 is the start register. Channel n occupies addresses 4n+4 to 4n+7: constant, counter, control and capture, in that order.

Top module: `reload_timer`

## Requirements
- R1: After reset, every counter and constant reads 0xFFFFFFFF, every control word and the start register read 0, all interrupts are low, and pin_oe_o is 1.
- R2: A channel counts only while its run bit is 1. Start register bits 0 to 2 are the run bits for channels 0 to 2.
- R3: When a count event arrives with the counter at 0, the counter loads the constant and control bit 6 (the underflow flag) is set. Otherwise the counter decrements by one. The period is therefore constant+1 events.
- R4: Control field [2:0] values 0 to 4 select an internal tick at the block clock divided by 4, 16, 64, 256 and 1024 respectively.
- R5: Control field [2:0] values 5 to 7 select the external clock pin. Field [4:3] picks the counted edges: 00 rising, 01 falling, 1x both. Edges count only while start register bit 8 (pin input enable) is 1, and pin_oe_o is the inverse of that bit. A pin change is counted at the third rising clock edge after it.
- R6: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A hardware set in the same cycle as a clearing write wins.
- R7: unf_irq_o[n] is high exactly while channel n's underflow flag and its enable (control bit 5) are both 1.
- R8: On channel 2, when control bit 7 is 1, the selected edge of cap_pin_i (field [4:3], same encoding as R5) copies the counter into the capture register (address 15) and sets control bit 9. cap_irq_o is high while bit 9 and bit 8 are both 1. Capture works whether or not the channel is running.
- R9: A write to a counter address loads that value into the counter, and it takes priority over a count event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | block clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| we_i | input | 1 | register write strobe |
| addr_i | input | 4 | word address |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data, combinational from addr_i |
| ext_clk_i | input | 1 | external count clock pin |
| cap_pin_i | input | 1 | capture pin for channel 2 |
| pin_oe_o | output | 1 | drive enable for the external clock pin |
| unf_irq_o | output | 3 | underflow interrupt per channel |
| cap_irq_o | output | 1 | capture interrupt |

## Verification
A register write is visible on rdata_o from the negative edge after the strobed rising edge. The bench drives and samples only on negative edges, so it always reads after the write has landed. External and capture pin changes take effect at the third rising edge after the change, because of the two synchronizer stages and the edge register. The bench therefore holds each pin level for four cycles before moving on, and it times the same-cycle clear-versus-set case to land exactly on that third edge. Internal prescaler checks run for a window of whole tick periods, so the exact decrement is known without knowing the prescaler phase.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
  localparam int CNT_W  = 32;
  localparam int NUM_CH = 3;
  localparam int TAPS   = 5;
  localparam int CTRL_W = 10;

  typedef struct packed {
    logic       cap_flag;
    logic       cap_ie;
    logic       cap_en;
    logic       unf_flag;
    logic       unf_ie;
    logic [1:0] edge_sel;
    logic [2:0] clk_sel;
  } ctrl_t;

  function automatic logic edge_pick(input logic [1:0] mode, input logic rise, input logic fall);
    if (mode[1]) return rise | fall;
    return mode[0] ? fall : rise;
  endfunction
endpackage

// File: rtl/reload_timer_prescale.sv
module reload_timer_prescale #(
  parameter int TAPS = 5,
  localparam int DIV_W = 2 * TAPS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TAPS-1:0] tick_o
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;

  // tap k pulses once every 4^(k+1) cycles
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign tick_o[k] = &div_q[2*k+1:0];
  end

  assert_tick_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o[0] |=> !tick_o[0]);
endmodule

// File: rtl/reload_timer_edge.sv
module reload_timer_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], pin_i};

  assign rise_o = sh_q[1] & ~sh_q[2];
  assign fall_o = ~sh_q[1] & sh_q[2];

  assert_edge_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/reload_timer_channel.sv
module reload_timer_channel
  import reload_timer_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int TAPS    = 5,
  parameter bit HAS_CAP = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [TAPS-1:0]  tick_int_i,
  input  logic             ext_en_i,
  input  logic             ext_rise_i,
  input  logic             ext_fall_i,
  input  logic             cap_rise_i,
  input  logic             cap_fall_i,
  input  logic             const_we_i,
  input  logic             cnt_we_i,
  input  logic             ctrl_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] const_o,
  output logic [CNT_W-1:0] cnt_o,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             unf_irq_o,
  output logic             cap_irq_o
);
  ctrl_t ctrl_q, wr_ctrl;
  logic [CNT_W-1:0] cnt_q, const_q;
  logic tick, count_ev, underflow, cap_ev;

  assign wr_ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);

  always_comb begin
    tick = ext_en_i & edge_pick(ctrl_q.edge_sel, ext_rise_i, ext_fall_i);
    for (int k = 0; k < TAPS; k++)
      if (ctrl_q.clk_sel == 3'(k)) tick = tick_int_i[k];
  end

  assign count_ev  = run_i & tick;
  assign underflow = count_ev & (cnt_q == '0);
  assign cap_ev    = HAS_CAP & ctrl_q.cap_en & edge_pick(ctrl_q.edge_sel, cap_rise_i, cap_fall_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         const_q <= '1;
    else if (const_we_i) const_q <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       cnt_q <= '1;
    else if (cnt_we_i) cnt_q <= wdata_i;
    else if (count_ev) cnt_q <= underflow ? const_q : cnt_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ctrl_q <= '0;
    else begin
      if (ctrl_we_i) begin
        ctrl_q.clk_sel  <= wr_ctrl.clk_sel;
        ctrl_q.edge_sel <= wr_ctrl.edge_sel;
        ctrl_q.unf_ie   <= wr_ctrl.unf_ie;
        ctrl_q.cap_en   <= wr_ctrl.cap_en & HAS_CAP;
        ctrl_q.cap_ie   <= wr_ctrl.cap_ie & HAS_CAP;
        ctrl_q.unf_flag <= ctrl_q.unf_flag & wr_ctrl.unf_flag;
        ctrl_q.cap_flag <= ctrl_q.cap_flag & wr_ctrl.cap_flag;
      end
      // hardware set wins over a clearing write
      if (underflow) ctrl_q.unf_flag <= 1'b1;
      if (cap_ev)    ctrl_q.cap_flag <= 1'b1;
    end

  if (HAS_CAP) begin : g_cap
    logic [CNT_W-1:0] cap_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)     cap_q <= '0;
      else if (cap_ev) cap_q <= cnt_q;
    assign cap_o = cap_q;

    assert_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_ev |=> (cap_q == $past(cnt_q)));
  end else begin : g_nocap
    assign cap_o = '0;
  end

  assign const_o   = const_q;
  assign cnt_o     = cnt_q;
  assign ctrl_o    = ctrl_q;
  assign unf_irq_o = ctrl_q.unf_flag & ctrl_q.unf_ie;
  assign cap_irq_o = ctrl_q.cap_flag & ctrl_q.cap_ie;

  assert_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow && !cnt_we_i) |=> (cnt_q == $past(const_q)));
  assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow |=> ctrl_q.unf_flag);
  assert_flag_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !wdata_i[6] && !underflow) |=> !ctrl_q.unf_flag);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_we_i) |=> $stable(cnt_q));
  assert_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              ext_clk_i,
  input  logic              cap_pin_i,
  output logic              pin_oe_o,
  output logic [NUM_CH-1:0] unf_irq_o,
  output logic              cap_irq_o
);
  logic [NUM_CH-1:0] run_q;
  logic pin_in_en_q;
  logic [TAPS-1:0] tick;
  logic ext_rise, ext_fall, cap_rise, cap_fall;
  logic [CNT_W-1:0] const_w [NUM_CH];
  logic [CNT_W-1:0] cnt_w   [NUM_CH];
  logic [CNT_W-1:0] cap_w   [NUM_CH];
  ctrl_t            ctrl_w  [NUM_CH];
  logic [NUM_CH-1:0] cap_irq_w;

  wire start_we = we_i && (addr_i == 4'd0);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      run_q       <= '0;
      pin_in_en_q <= 1'b0;
    end else if (start_we) begin
      run_q       <= wdata_i[NUM_CH-1:0];
      pin_in_en_q <= wdata_i[8];
    end

  reload_timer_prescale #(.TAPS(TAPS)) u_presc (.clk_i, .rst_ni, .tick_o(tick));
  reload_timer_edge u_ext (.clk_i, .rst_ni, .pin_i(ext_clk_i), .rise_o(ext_rise), .fall_o(ext_fall));
  reload_timer_edge u_cap (.clk_i, .rst_ni, .pin_i(cap_pin_i), .rise_o(cap_rise), .fall_o(cap_fall));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    wire hit = we_i && (addr_i[3:2] == 2'(g + 1));
    reload_timer_channel #(.CNT_W(CNT_W), .TAPS(TAPS), .HAS_CAP(g == NUM_CH - 1)) u_ch (
      .clk_i, .rst_ni,
      .run_i(run_q[g]), .tick_int_i(tick), .ext_en_i(pin_in_en_q),
      .ext_rise_i(ext_rise), .ext_fall_i(ext_fall),
      .cap_rise_i(cap_rise), .cap_fall_i(cap_fall),
      .const_we_i(hit && addr_i[1:0] == 2'd0),
      .cnt_we_i(hit && addr_i[1:0] == 2'd1),
      .ctrl_we_i(hit && addr_i[1:0] == 2'd2),
      .wdata_i,
      .const_o(const_w[g]), .cnt_o(cnt_w[g]), .ctrl_o(ctrl_w[g]), .cap_o(cap_w[g]),
      .unf_irq_o(unf_irq_o[g]), .cap_irq_o(cap_irq_w[g]));
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == 4'd0) rdata_o = {23'b0, pin_in_en_q, 5'b0, run_q};
    for (int g = 0; g < NUM_CH; g++)
      if (addr_i[3:2] == 2'(g + 1))
        case (addr_i[1:0])
          2'd0:    rdata_o = const_w[g];
          2'd1:    rdata_o = cnt_w[g];
          2'd2:    rdata_o = {{(CNT_W-CTRL_W){1'b0}}, ctrl_w[g]};
          default: rdata_o = cap_w[g];
        endcase
  end

  assign pin_oe_o  = ~pin_in_en_q;
  assign cap_irq_o = |cap_irq_w;

  assert_no_ext_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pin_in_en_q && !(we_i && addr_i == 4'd5) && ctrl_w[0].clk_sel >= 3'd5) |=> $stable(cnt_w[0]));
endmodule

// File: tb/reload_timer_test.sv
`timescale 1ns/1ps
module reload_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, ext = 1'b0, cap = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic pin_oe, cap_irq;
  logic [2:0] unf_irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  reload_timer uut (.clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ext_clk_i(ext), .cap_pin_i(cap), .pin_oe_o(pin_oe),
    .unf_irq_o(unf_irq), .cap_irq_o(cap_irq));

  // const, init, pulses, edge mode, expected count, expected flag
  typedef struct packed { logic [31:0] c, i; int n; logic [1:0] m; logic [31:0] ec; logic ef; } vec_t;
  localparam vec_t VEC [6] = '{
    '{32'd5, 32'd3, 2, 2'b00, 32'd1, 1'b0},
    '{32'd5, 32'd3, 4, 2'b00, 32'd5, 1'b1},
    '{32'd2, 32'd1, 3, 2'b01, 32'd1, 1'b1},
    '{32'd3, 32'd2, 3, 2'b10, 32'd0, 1'b1},
    '{32'd0, 32'd0, 2, 2'b00, 32'd0, 1'b1},
    '{32'd7, 32'd7, 1, 2'b11, 32'd5, 1'b0}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_ext(input int n);
    for (int p = 0; p < n; p++) begin
      @(negedge clk); ext = 1'b1; repeat (4) @(negedge clk);
      ext = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic set_cap(input logic v);
    @(negedge clk); cap = v; repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd5, d);  chk("R1 count", d, 32'hFFFF_FFFF);
    rd(4'd4, d);  chk("R1 const", d, 32'hFFFF_FFFF);
    rd(4'd14, d); chk("R1 ctrl", d, 32'h0);
    rd(4'd0, d);  chk("R1 start", d, 32'h0);
    chk("R1 irqs", {28'b0, cap_irq, unf_irq}, 32'h0);
    chk("R1 oe", {31'b0, pin_oe}, 32'h1);

    // R3 R5 vector walk on channel 0 with the external clock
    foreach (VEC[v]) begin
      wr(4'd0, 32'h0);
      wr(4'd6, 32'd5 | (32'(VEC[v].m) << 3));
      wr(4'd4, VEC[v].c);
      wr(4'd5, VEC[v].i);
      wr(4'd0, 32'h101);
      pulse_ext(VEC[v].n);
      wr(4'd0, 32'h100);
      rd(4'd5, d); chk("R3/R5 vector count", d, VEC[v].ec);
      rd(4'd6, d); chk("R3 vector flag", {31'b0, d[6]}, {31'b0, VEC[v].ef});
    end

    // R9 direct count write
    wr(4'd5, 32'hDEAD_BEEF);
    rd(4'd5, d); chk("R9 count load", d, 32'hDEAD_BEEF);

    // R2 stopped channel ignores edges
    wr(4'd6, 32'd5); wr(4'd5, 32'd9); wr(4'd0, 32'h100);
    pulse_ext(2);
    rd(4'd5, d); chk("R2 hold when stopped", d, 32'd9);

    // R5 pin input disabled: edges ignored, oe high
    wr(4'd0, 32'h001);
    chk("R5 oe when pin disabled", {31'b0, pin_oe}, 32'h1);
    pulse_ext(2);
    rd(4'd5, d); chk("R5 gated pin", d, 32'd9);
    wr(4'd0, 32'h101);
    chk("R5 oe when pin enabled", {31'b0, pin_oe}, 32'h0);
    wr(4'd0, 32'h100);

    // R4 internal taps over whole periods
    wr(4'd6, 32'd0); wr(4'd5, 32'd1000); wr(4'd0, 32'h1);
    repeat (398) @(negedge clk);
    wr(4'd0, 32'h0);
    rd(4'd5, d); chk("R4 div4", d, 32'd900);
    wr(4'd6, 32'd1); wr(4'd5, 32'd1000); wr(4'd0, 32'h1);
    repeat (318) @(negedge clk);
    wr(4'd0, 32'h0);
    rd(4'd5, d); chk("R4 div16", d, 32'd980);

    // R6 write 1 to a clear flag does nothing; clearing write loses to a same-cycle set
    wr(4'd6, 32'd5 | 32'h40);
    rd(4'd6, d); chk("R6 write one no effect", {31'b0, d[6]}, 32'h0);
    wr(4'd4, 32'd0); wr(4'd5, 32'd0); wr(4'd0, 32'h101);
    @(negedge clk); ext = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); we = 1'b1; addr = 4'd6; wdata = 32'd5;
    @(negedge clk); we = 1'b0;
    rd(4'd6, d); chk("R6 set beats clear", {31'b0, d[6]}, 32'h1);
    @(negedge clk); ext = 1'b0; repeat (4) @(negedge clk);
    wr(4'd0, 32'h100);

    // R7 interrupt follows flag and enable
    chk("R7 irq off without enable", {29'b0, unf_irq}, 32'h0);
    wr(4'd6, 32'd5 | 32'h60);
    chk("R7 irq on", {29'b0, unf_irq}, 32'h1);
    wr(4'd6, 32'd5 | 32'h20);
    chk("R6/R7 clear drops irq", {29'b0, unf_irq}, 32'h0);
    rd(4'd6, d); chk("R6 flag cleared", {31'b0, d[6]}, 32'h0);

    // R8 capture on channel 2
    wr(4'd13, 32'h1234); wr(4'd14, 32'h180);
    set_cap(1'b1); set_cap(1'b0);
    rd(4'd15, d); chk("R8 capture value", d, 32'h1234);
    rd(4'd14, d); chk("R8 capture flag", {31'b0, d[9]}, 32'h1);
    chk("R8 capture irq", {31'b0, cap_irq}, 32'h1);
    wr(4'd14, 32'h188);
    chk("R8 capture irq cleared", {31'b0, cap_irq}, 32'h0);
    wr(4'd13, 32'h55);
    set_cap(1'b1);
    rd(4'd15, d); chk("R8 falling mode ignores rise", d, 32'h1234);
    set_cap(1'b0);
    rd(4'd15, d); chk("R8 falling capture", d, 32'h55);
    wr(4'd14, 32'h100); wr(4'd13, 32'h77);
    set_cap(1'b1); set_cap(1'b0);
    rd(4'd15, d); chk("R8 disabled capture", d, 32'h55);
    rd(4'd14, d); chk("R8 disabled flag", {31'b0, d[9]}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule